// File: doc/BRIEF.md
# Memory access watchdog counter

This block guards the handshake between a requester and an attached message memory. When an access begins, a down-counter is loaded with a programmable reload value. It then counts down by one on every clock of the peripheral bus clock for as long as the access is outstanding. Each ready pulse from the memory reloads the counter and completes the access.

If the counter reaches zero before ready arrives, it stops at zero and raises a sticky watchdog flag. The flag stays set until a write-one-to-clear pulse removes it. The current count is always visible for status reads. A reload value of zero turns the watchdog off.

Top module: `mem_access_watchdog`

## Requirements
- R1: After reset, `count` is 0, `wd_flag` is 0 and no access is outstanding.
- R2: A cycle with `access_start` high loads `count` with `reload_val` at that clock edge, and marks an access as outstanding when `reload_val` is nonzero.
- R3: While an access is outstanding and neither `access_start` nor `mem_ready` is high, `count` decreases by exactly one per clock.
- R4: A cycle with `mem_ready` high and `access_start` low loads `count` with `reload_val` and ends the outstanding access.
- R5: When no access is outstanding and neither `access_start` nor `mem_ready` is high, `count` holds its value.
- R6: When an outstanding access counts down from 1 to 0, `wd_flag` is set at that same edge, the access ends, and `count` stays at 0 afterwards.
- R7: `wd_flag` stays set until a cycle with `flag_clr` high, which clears it at that edge.
- R8: If a timeout and `flag_clr` occur in the same cycle, `wd_flag` ends up set.
- R9: With `reload_val` equal to 0, a start loads 0, no access becomes outstanding and `wd_flag` is never set.
- R10: When `access_start` and `mem_ready` are high in the same cycle, the start wins: `count` is loaded and the access stays outstanding, counting down afterwards.
- R11: Starting a new access does not clear a set `wd_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| access_start | input | 1 | Pulse when a memory access begins |
| mem_ready | input | 1 | Pulse when the memory completes an access |
| reload_val | input | CNT_W | Configured watchdog reload value; 0 disables |
| flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| count | output | CNT_W | Current counter value |
| wd_flag | output | 1 | Sticky watchdog timeout flag |

## Verification
Both outputs are registered, so each one reflects a stimulus at the first rising edge after it. A start with reload value N therefore raises the flag N edges after the start edge if no ready arrives. The driver applies inputs on the falling edge and pushes the expected count and flag for each cycle after the following rising edge. The monitor compares each queued item at the next falling edge, so every result is checked exactly one edge after its cause.

// File: rtl/mem_access_watchdog.sv
module mem_access_watchdog #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             access_start,
  input  logic             mem_ready,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             wd_flag
);

  localparam logic [CNT_W-1:0] ONE = 1;

  logic busy;

  wire enabled = (reload_val != '0);
  wire expire  = busy && !access_start && !mem_ready && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      busy  <= 1'b0;
    end else if (access_start) begin
      count <= reload_val;
      busy  <= enabled;
    end else if (mem_ready) begin
      count <= reload_val;
      busy  <= 1'b0;
    end else if (busy) begin
      count <= count - ONE;
      if (count == ONE) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wd_flag <= 1'b0;
    else if (expire)   wd_flag <= 1'b1;
    else if (flag_clr) wd_flag <= 1'b0;
  end

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    access_start |=> count == $past(reload_val));

  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !access_start && !mem_ready |=> count == $past(count) - ONE);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !access_start && !mem_ready |=> $stable(count));

  a_r6_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_flag) |-> count == '0);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wd_flag && !flag_clr |=> wd_flag);

  a_r9_busy_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> count != '0);

endmodule

// File: tb/test_mem_access_watchdog.sv
module test_mem_access_watchdog;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         access_start = 1'b0;
  logic         mem_ready = 1'b0;
  logic [W-1:0] reload_val = '0;
  logic         flag_clr = 1'b0;
  logic [W-1:0] count;
  logic         wd_flag;

  always #10 clk = ~clk;

  mem_access_watchdog #(.CNT_W(W)) i_mem_access_watchdog (
    .clk(clk), .rst_n(rst_n), .access_start(access_start), .mem_ready(mem_ready),
    .reload_val(reload_val), .flag_clr(flag_clr), .count(count), .wd_flag(wd_flag)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [W-1:0] q_cnt[$];
  logic         q_flg[$];
  string        q_tag[$];

  logic [W-1:0] m_cnt = '0;
  logic         m_flg = 1'b0;
  logic         m_busy = 1'b0;

  task automatic step(input logic st, input logic rd, input logic clr,
                      input logic [W-1:0] rv, input string tag);
    logic set;
    @(negedge clk);
    access_start = st; mem_ready = rd; flag_clr = clr; reload_val = rv;
    set = 1'b0;
    if (st) begin
      m_cnt = rv; m_busy = (rv != 0);
    end else if (rd) begin
      m_cnt = rv; m_busy = 1'b0;
    end else if (m_busy) begin
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) begin m_busy = 1'b0; set = 1'b1; end
    end
    if (set) m_flg = 1'b1;
    else if (clr) m_flg = 1'b0;
    @(posedge clk);
    #1;
    q_cnt.push_back(m_cnt); q_flg.push_back(m_flg); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, reload_val, tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q_cnt.size() != 0) begin
        logic [W-1:0] ec;
        logic ef;
        string t;
        ec = q_cnt.pop_front(); ef = q_flg.pop_front(); t = q_tag.pop_front();
        compared++;
        if (count !== ec || wd_flag !== ef) begin
          mismatched++;
          $display("FAIL %s: count=%0d flag=%0b expected count=%0d flag=%0b",
                   t, count, wd_flag, ec, ef);
        end
      end
    end
  end

  initial begin : watchdog
    #4_000_000;
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    done = 1'b1;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    compared++;
    if (count !== '0 || wd_flag !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: count=%0d flag=%0b expected count=0 flag=0", count, wd_flag);
    end
    rst_n = 1'b1;
    idle(2, "R1 idle after reset");
    step(1'b1, 1'b0, 1'b0, 8'd5, "R2 start loads 5");
    idle(4, "R3 countdown");
    idle(1, "R6 timeout to zero sets flag");
    idle(3, "R6 stays at zero");
    idle(2, "R7 flag sticky");
    step(1'b0, 1'b0, 1'b1, reload_val, "R7 clear flag");
    step(1'b1, 1'b0, 1'b0, 8'd4, "R2 start loads 4");
    idle(2, "R3 countdown");
    step(1'b0, 1'b1, 1'b0, 8'd9, "R4 ready reloads 9");
    idle(12, "R5 hold after ready");
    step(1'b0, 1'b1, 1'b0, 8'd7, "R4 ready with no access loads");
    idle(3, "R5 hold idle");
    step(1'b1, 1'b1, 1'b0, 8'd3, "R10 start and ready together");
    idle(2, "R10 countdown continues");
    step(1'b0, 1'b0, 1'b1, reload_val, "R8 timeout beats clear");
    idle(2, "R8 flag remains set");
    step(1'b1, 1'b0, 1'b0, 8'd6, "R11 start keeps flag");
    idle(3, "R11 flag still set while counting");
    step(1'b0, 1'b0, 1'b1, 8'd6, "R7 clear during access");
    step(1'b0, 1'b1, 1'b0, 8'd6, "R4 ready ends access");
    step(1'b1, 1'b0, 1'b0, 8'd0, "R9 start with zero reload");
    idle(10, "R9 disabled no flag");
    step(1'b1, 1'b0, 1'b0, 8'd255, "R2 start loads max");
    idle(255, "R3 R6 full-range timeout");
    idle(2, "R6 frozen at zero");
    step(1'b0, 1'b0, 1'b1, reload_val, "R7 final clear");
    idle(2, "R5 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule